// File: doc/BRIEF.md
# Two-Stage Threshold Energy Accumulator

This block turns a stream of signed per-phase power samples into energy counts in two stages. A sample strobe arrives at the sample rate, nominally 8 kHz. On each strobe, every phase adds its power sample to a wide signed accumulator. When the new sum reaches the programmed threshold, the phase emits a one-cycle positive energy pulse and the threshold is taken off the sum. When the sum falls to or below the negated threshold, the phase emits a negative pulse and the threshold is added back.

The second stage counts these pulses per phase in a signed two's-complement counter that wraps. A read of one phase returns that counter's value and restarts the counter. A pulse that lands in the same cycle as the read is kept for the next read, so no energy is lost or counted twice.

The threshold is wider than one bus word, so it is written in two halves. A new threshold takes effect only after both halves have been written. A zero threshold stops all pulse generation.

Top module: `energy_integrator`

## Requirements
- R1: While `rst_n` is low, and after its release, all accumulators, counters, staged threshold halves, the active threshold, `pulse_pos`, `pulse_neg` and `rd_data` are zero.
- R2: In a cycle with `sample_stb` high, each phase forms sum = accumulator + sign-extended sample, wrapping at ACC_W bits. If the threshold is nonzero and sum >= threshold, the next cycle carries a one-cycle `pulse_pos` for that phase and the accumulator becomes sum − threshold.
- R3: If the threshold is nonzero and sum <= −threshold, the next cycle carries a one-cycle `pulse_neg` for that phase and the accumulator becomes sum + threshold.
- R4: Each phase emits at most one pulse per strobe. Any energy above one threshold stays in the accumulator for later strobes.
- R5: While the active threshold is zero, no pulse is produced and the accumulator keeps the plain wrapping sum.
- R6: A write with `thr_wr_en` high stages bits [THR_W/2−1:0] of `thr_wr_data` as the low half (`thr_wr_hi`=0) or the high half (`thr_wr_hi`=1). The upper word bits are ignored. The active threshold changes, from the next cycle, only when both halves have been staged since the last change, in either order. A strobe in the same cycle as the completing write still uses the old threshold.
- R7: Each phase counter adds 1 for a `pulse_pos` and subtracts 1 for a `pulse_neg`, wrapping as a CNT_W-bit two's-complement value: from the most positive value to the most negative when counting up, and the reverse when counting down.
- R8: A cycle with `rd_en` high and `rd_sel` = k loads `rd_data`, from the next cycle on, with phase k's counter value of that cycle, sign-extended to WORD_W. Phase k's counter then restarts from that cycle's pulse of phase k (+1, −1 or 0). A `rd_sel` of NPH or more loads zero and clears nothing. `rd_data` changes only after a read.
- R9: Without a strobe, accumulators hold their value and no pulse is produced, whatever the power inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe that marks a new power sample |
| power_in | input | NPH*PWR_W | Signed power samples, phase i in bits [i*PWR_W +: PWR_W] |
| thr_wr_en | input | 1 | Threshold half write enable |
| thr_wr_hi | input | 1 | Selects which half is written: 0 low, 1 high |
| thr_wr_data | input | WORD_W | Write word; only its low THR_W/2 bits are used |
| pulse_pos | output | NPH | One-cycle positive energy pulse per phase |
| pulse_neg | output | NPH | One-cycle negative energy pulse per phase |
| rd_en | input | 1 | Read strobe: transfer and restart the selected counter |
| rd_sel | input | SEL_W | Phase index to read |
| rd_data | output | WORD_W | Last transferred counter value, sign-extended |

## Verification
The bench builds the block with NPH=3, PWR_W=12, ACC_W=24, THR_W=16, CNT_W=6 and WORD_W=32. With a 6-bit counter, a few dozen pulses are enough to wrap the counter in both directions. A 16-bit threshold written as two 8-bit halves leaves room in the upper word bits for junk, which the block must ignore. Samples near full scale against small thresholds cause an overshoot on every strobe, so the one-pulse-per-strobe limit is exercised. Reads issued while strobes run back to back make pulses coincide with the counter transfer.

// File: rtl/energy_acc_pkg.sv
package energy_acc_pkg;
   typedef enum logic {
      THR_HALF_LO = 1'b0,
      THR_HALF_HI = 1'b1
   } thr_half_e;

   typedef struct packed {
      logic up;
      logic down;
   } epulse_t;
endpackage

// File: rtl/energy_stage1.sv
module energy_stage1
   import energy_acc_pkg::*;
#(
   parameter int PWR_W = 28,
   parameter int ACC_W = 56,
   parameter int THR_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [PWR_W-1:0] power,
   input  logic [THR_W-1:0] thr,
   output epulse_t          pulse
);
   localparam int PAD_P = ACC_W - PWR_W;
   localparam int PAD_T = ACC_W - THR_W;

   logic signed [ACC_W-1:0] acc_q, sum, thr_s, pw_s;
   logic                    thr_nz, hit_up, hit_dn;

   always_comb begin
      pw_s   = {{PAD_P{power[PWR_W-1]}}, power};
      thr_s  = {{PAD_T{1'b0}}, thr};
      sum    = acc_q + pw_s;
      thr_nz = |thr;
      hit_up = thr_nz && (sum >= thr_s);
      hit_dn = thr_nz && (sum <= -thr_s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pulse <= '0;
      end else begin
         pulse <= '0;
         if (stb) begin
            if (hit_up) begin
               acc_q    <= sum - thr_s;
               pulse.up <= 1'b1;
            end else if (hit_dn) begin
               acc_q      <= sum + thr_s;
               pulse.down <= 1'b1;
            end else begin
               acc_q <= sum;
            end
         end
      end
   end

   // R4: never both directions at once
   p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse.up && pulse.down));
   // R9: a pulse only follows a strobe
   p_pulse_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stb == 1'b0) |=> (pulse == '0));
   // R5: zero threshold yields no pulse
   p_zero_thr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '0) |=> (pulse == '0));
endmodule

// File: rtl/energy_stage2.sv
module energy_stage2
   import energy_acc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  epulse_t          pulse,
   input  logic             rd_hit,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] delta;

   always_comb begin
      unique case ({pulse.up, pulse.down})
         2'b10:   delta = CNT_W'(1);
         2'b01:   delta = '1;
         default: delta = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (rd_hit) cnt <= delta;
      else             cnt <= cnt + delta;
   end

   // R7: counter idles without pulses or reads
   p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && pulse == '0) |=> $stable(cnt));
   // R8: a read restarts the counter at a small value
   p_read_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && pulse == '0) |=> (cnt == '0));
endmodule

// File: rtl/energy_thr_regs.sv
module energy_thr_regs
   import energy_acc_pkg::*;
#(
   parameter int THR_W  = 48,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  thr_half_e         wr_half,
   input  logic [WORD_W-1:0] wr_data,
   output logic [THR_W-1:0]  thr
);
   localparam int HALF = THR_W / 2;

   logic [HALF-1:0] lo_q, hi_q;
   logic            lo_seen, hi_seen;
   logic            unused_upper;

   assign unused_upper = ^wr_data[WORD_W-1:HALF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         lo_seen <= 1'b0;
         hi_seen <= 1'b0;
         thr     <= '0;
      end else if (wr_en) begin
         if (wr_half == THR_HALF_LO) begin
            lo_q <= wr_data[HALF-1:0];
            if (hi_seen) begin
               thr     <= {hi_q, wr_data[HALF-1:0]};
               hi_seen <= 1'b0;
               lo_seen <= 1'b0;
            end else begin
               lo_seen <= 1'b1;
            end
         end else begin
            hi_q <= wr_data[HALF-1:0];
            if (lo_seen) begin
               thr     <= {wr_data[HALF-1:0], lo_q};
               hi_seen <= 1'b0;
               lo_seen <= 1'b0;
            end else begin
               hi_seen <= 1'b1;
            end
         end
      end
   end

   // R6: active threshold moves only on a write
   p_thr_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(thr));
endmodule

// File: rtl/energy_integrator.sv
module energy_integrator
   import energy_acc_pkg::*;
#(
   parameter int NPH    = 3,
   parameter int PWR_W  = 28,
   parameter int ACC_W  = 56,
   parameter int THR_W  = 48,
   parameter int CNT_W  = 32,
   parameter int WORD_W = 32,
   localparam int SEL_W = (NPH > 1) ? $clog2(NPH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_stb,
   input  logic [NPH*PWR_W-1:0] power_in,
   input  logic                 thr_wr_en,
   input  logic                 thr_wr_hi,
   input  logic [WORD_W-1:0]    thr_wr_data,
   output logic [NPH-1:0]       pulse_pos,
   output logic [NPH-1:0]       pulse_neg,
   input  logic                 rd_en,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [WORD_W-1:0]    rd_data
);
   generate
      if (NPH < 1)                $error("NPH must be at least 1");
      if (THR_W % 2 != 0)         $error("THR_W must be even");
      if (THR_W / 2 >= WORD_W)    $error("threshold half must fit below WORD_W");
      if (ACC_W < THR_W + 2)      $error("ACC_W must exceed THR_W by two bits");
      if (ACC_W <= PWR_W)         $error("ACC_W must exceed PWR_W");
      if (CNT_W < 2 || CNT_W > WORD_W) $error("CNT_W out of range");
   endgenerate

   logic [THR_W-1:0] thr;
   logic [CNT_W-1:0] cnt [NPH];
   logic [CNT_W-1:0] sel_cnt;
   logic [WORD_W-1:0] rd_next;

   energy_thr_regs #(.THR_W(THR_W), .WORD_W(WORD_W)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (thr_wr_en),
      .wr_half (thr_half_e'(thr_wr_hi)),
      .wr_data (thr_wr_data),
      .thr     (thr)
   );

   for (genvar i = 0; i < NPH; i++) begin : g_ph
      epulse_t pl;
      energy_stage1 #(.PWR_W(PWR_W), .ACC_W(ACC_W), .THR_W(THR_W)) u_s1 (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (sample_stb),
         .power (power_in[i*PWR_W +: PWR_W]),
         .thr   (thr),
         .pulse (pl)
      );
      energy_stage2 #(.CNT_W(CNT_W)) u_s2 (
         .clk    (clk),
         .rst_n  (rst_n),
         .pulse  (pl),
         .rd_hit (rd_en && (rd_sel == SEL_W'(i))),
         .cnt    (cnt[i])
      );
      assign pulse_pos[i] = pl.up;
      assign pulse_neg[i] = pl.down;
   end

   always_comb begin
      sel_cnt = '0;
      for (int i = 0; i < NPH; i++)
         if (rd_sel == SEL_W'(i)) sel_cnt = cnt[i];
   end

   if (CNT_W == WORD_W) begin : g_ext_none
      assign rd_next = sel_cnt;
   end else begin : g_ext_sign
      assign rd_next = {{(WORD_W-CNT_W){sel_cnt[CNT_W-1]}}, sel_cnt};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   // R8: read data changes only after a read
   p_rd_only_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_energy_integrator.sv
module sim_energy_integrator;
   localparam int NPH = 3, PWR_W = 12, ACC_W = 24, THR_W = 16, CNT_W = 6, WORD_W = 32;
   localparam int SEL_W = 2;

   logic clk = 0, rst_n = 0, sample_stb = 0, thr_wr_en = 0, thr_wr_hi = 0, rd_en = 0;
   logic [NPH*PWR_W-1:0] power_in = '0;
   logic [WORD_W-1:0] thr_wr_data = '0;
   logic [SEL_W-1:0] rd_sel = '0;
   logic [NPH-1:0] pulse_pos, pulse_neg;
   logic [WORD_W-1:0] rd_data;

   energy_integrator #(.NPH(NPH), .PWR_W(PWR_W), .ACC_W(ACC_W), .THR_W(THR_W),
                       .CNT_W(CNT_W), .WORD_W(WORD_W)) u0 (.*);

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string tag = "R1";
   bit done = 0;

   // behavioural reference state
   int m_acc [NPH], m_cnt [NPH], m_pp [NPH], m_pn [NPH];
   int m_thr = 0, m_lo = 0, m_hi = 0, m_rd = 0;
   bit m_lo_seen = 0, m_hi_seen = 0;

   function automatic int wrapw(int v, int w);
      int r;
      r = v & ((1 << w) - 1);
      if (r >= (1 << (w - 1))) r = r - (1 << w);
      return r;
   endfunction

   initial for (int i = 0; i < NPH; i++) begin
      m_acc[i] = 0; m_cnt[i] = 0; m_pp[i] = 0; m_pn[i] = 0;
   end

   always @(posedge clk) begin
      int s, half;
      if (!rst_n) begin
         for (int i = 0; i < NPH; i++) begin
            m_acc[i] = 0; m_cnt[i] = 0; m_pp[i] = 0; m_pn[i] = 0;
         end
         m_thr = 0; m_lo = 0; m_hi = 0; m_rd = 0; m_lo_seen = 0; m_hi_seen = 0;
      end else begin
         if (rd_en) m_rd = (int'(rd_sel) < NPH) ? m_cnt[rd_sel] : 0;
         for (int i = 0; i < NPH; i++) begin
            if (rd_en && int'(rd_sel) == i) m_cnt[i] = m_pp[i] - m_pn[i];
            else m_cnt[i] = wrapw(m_cnt[i] + m_pp[i] - m_pn[i], CNT_W);
         end
         for (int i = 0; i < NPH; i++) begin
            m_pp[i] = 0; m_pn[i] = 0;
            if (sample_stb) begin
               s = wrapw(m_acc[i] + wrapw(int'(power_in[i*PWR_W +: PWR_W]), PWR_W), ACC_W);
               if (m_thr != 0 && s >= m_thr) begin s = s - m_thr; m_pp[i] = 1; end
               else if (m_thr != 0 && s <= -m_thr) begin s = s + m_thr; m_pn[i] = 1; end
               m_acc[i] = s;
            end
         end
         if (thr_wr_en) begin
            half = int'(thr_wr_data[THR_W/2-1:0]);
            if (!thr_wr_hi) begin
               m_lo = half;
               if (m_hi_seen) begin m_thr = m_hi * (1 << (THR_W/2)) + half; m_lo_seen = 0; m_hi_seen = 0; end
               else m_lo_seen = 1;
            end else begin
               m_hi = half;
               if (m_lo_seen) begin m_thr = half * (1 << (THR_W/2)) + m_lo; m_lo_seen = 0; m_hi_seen = 0; end
               else m_hi_seen = 1;
            end
         end
      end
   end

   task automatic check(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) if (!done) begin
      cycles++;
      for (int i = 0; i < NPH; i++) begin
         check($sformatf("pulse_pos[%0d]", i), int'(pulse_pos[i]), m_pp[i]);
         check($sformatf("pulse_neg[%0d]", i), int'(pulse_neg[i]), m_pn[i]);
      end
      check("rd_data", int'($signed(rd_data)), m_rd);
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_pw(int p0, int p1, int p2);
      power_in = {PWR_W'(p2), PWR_W'(p1), PWR_W'(p0)};
   endtask

   task automatic wr_thr(bit hi, logic [31:0] d);
      thr_wr_en = 1; thr_wr_hi = hi; thr_wr_data = d;
      tick();
      thr_wr_en = 0; thr_wr_data = 32'hDEAD_BEEF;
   endtask

   task automatic strobes(int n, int gap);
      for (int k = 0; k < n; k++) begin
         sample_stb = 1; tick(); sample_stb = 0;
         if (gap > 0) tick(gap);
      end
   endtask

   task automatic rd(int sel);
      rd_en = 1; rd_sel = SEL_W'(sel); tick(); rd_en = 0;
   endtask

   initial begin
      tag = "R1";
      tick(4);
      rst_n = 1;
      tick(2);
      tag = "R5";
      set_pw(900, -900, 2000);
      strobes(20, 1);
      rd(0); rd(2);
      tag = "R6";
      wr_thr(0, 32'h1234_56E8);
      strobes(5, 0);
      wr_thr(0, 32'hFFFF_FFE8);
      strobes(3, 0);
      thr_wr_en = 1; thr_wr_hi = 1; thr_wr_data = 32'hAB00_0003; sample_stb = 1;
      tick();
      thr_wr_en = 0; sample_stb = 0;
      tag = "R2";
      set_pw(300, 250, 700);
      strobes(40, 1);
      tag = "R3";
      set_pw(-2000, -300, -1);
      strobes(40, 0);
      tag = "R4";
      set_pw(2047, -2048, 1500);
      strobes(30, 0);
      tag = "R8";
      for (int k = 0; k < 60; k++) begin
         sample_stb = 1;
         rd_en = (k % 5 == 0); rd_sel = SEL_W'((k / 5) % 4);
         tick();
      end
      sample_stb = 0; rd_en = 0;
      rd(3); rd(0); rd(1); rd(2);
      tag = "R6";
      wr_thr(1, 32'h0000_0000);
      wr_thr(0, 32'h0000_0010);
      tag = "R7";
      set_pw(2047, -2047, 2047);
      strobes(80, 0);
      rd(0); rd(1); rd(2);
      set_pw(-2047, 2047, 0);
      strobes(80, 0);
      rd(0); rd(1); rd(2);
      tag = "R9";
      for (int k = 0; k < 10; k++) begin
         set_pw(k * 100, -k * 50, 2047 - k);
         tick();
      end
      rd(0); rd(1);
      tag = "R2";
      strobes(10, 2);
      tick(3);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule